// File: doc/BRIEF.md
# LUT-Based Configurable Logic Block

This block is a single logic cell whose behaviour is set entirely by configuration bits. Two 4-input lookup tables (F and G) each read one bit from a 16-entry truth table. A 3-input lookup table (H) takes the F result, the G result and one direct input, and reads one bit from an 8-entry table. Two output paths each pick a source (a 4-input table or H) and then pick the combinational value or a flip-flop copy of it.

The configuration is a 44-bit serial shift chain loaded at start-up while a configure-enable input is high. The chain holds the three truth tables and four path-select bits. While the cell is being configured its outputs stay low. After loading, the cell evaluates its functions every cycle.

The cell can form two independent 4-input functions plus a 3-input function of those results. With H acting as a 2:1 selector between F and G, it can form any function of five inputs. It can also form chosen 9-input functions, such as parity of nine bits.

Top module: `clb_cell`

## Requirements
- R1: A synchronous active-high reset clears every configuration bit and both flip-flops. After reset, both outputs read 0.
- R2: On each rising edge with `cfg_en` high, the chain shifts by one and `cfg_in` enters at bit 0. After 44 shifts, the first bit sent sits at bit 43. Chain layout: F table at bits 15:0 (entry n at bit n), G table at bits 31:16, H table at bits 39:32, X source select at bit 40, X register select at bit 41, Y source select at bit 42, Y register select at bit 43.
- R3: While `cfg_en` is low, the chain keeps its contents whatever `cfg_in` does.
- R4: The F result is F-table entry `f_in`, and the G result is G-table entry `g_in` (input bit 0 is the least significant address bit).
- R5: The H result is H-table entry {`h_in`, G result, F result}, with the F result as address bit 0.
- R6: When the X source select is 0, X uses the F result; when it is 1, X uses H. When the Y source select is 0, Y uses the G result; when it is 1, Y uses H.
- R7: When a path's register select is 1, its output shows the selected source as sampled at the previous rising edge. When it is 0, the output follows the source combinationally.
- R8: While `cfg_en` is high, `x_out` and `y_out` are 0.
- R9: With H table 0xCA, X on H, and the same four inputs on F and G, X realizes any 5-input function. The 32-bit truth table is split with its low half in F and its high half in G, and `h_in` is the fifth input.
- R10: With F and G tables 0x6996 and H table 0x96, the combinational X output equals the parity of all nine inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data |
| f_in | input | 4 | Address inputs of the F table |
| g_in | input | 4 | Address inputs of the G table |
| h_in | input | 1 | Direct input to the H table (address bit 2) |
| x_out | output | 1 | First cell output |
| y_out | output | 1 | Second cell output |

## Verification
A wrong configuration bit shows up at `x_out` or `y_out` only when the inputs address that table entry. The bench therefore walks many input patterns under several configurations, so every entry is read at least once. A shift that misplaces or drops a bit moves an entire field, and the next combinational check exposes it in the same cycle. A wrong flip-flop path shows as a one-cycle lag or lead against the combinational model, so registered checks are made both before and after the capturing edge.

// File: rtl/clb_pkg.sv
package clb_pkg;

    localparam int LUT_K    = 4;
    localparam int LUT_BITS = 1 << LUT_K;
    localparam int HK       = 3;
    localparam int H_BITS   = 1 << HK;
    localparam int N_PATHS  = 2;
    localparam int SEL_BITS = 2 * N_PATHS;
    localparam int CFG_W    = 2 * LUT_BITS + H_BITS + SEL_BITS;

    // Declared from the most significant field down to bit 0.
    typedef struct packed {
        logic                y_reg;
        logic                y_src;
        logic                x_reg;
        logic                x_src;
        logic [H_BITS-1:0]   h_tab;
        logic [LUT_BITS-1:0] g_tab;
        logic [LUT_BITS-1:0] f_tab;
    } cell_cfg_t;

endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tab,
    input  logic [K-1:0]      addr,
    output logic              dout
);
    always_comb begin
        dout = tab[addr];
    end
endmodule

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
    parameter int W = 44
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sin,
    output logic [W-1:0] bits
);
    typedef struct packed {
        logic [W-1:0] chain;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.chain = {st_q.chain[W-2:0], sin};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.chain;

    AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (st_q.chain[0] == $past(sin))); // R2

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(st_q.chain)); // R3
endmodule

// File: rtl/clb_out_path.sv
module clb_out_path (
    input  logic clk,
    input  logic rst,
    input  logic quiet,
    input  logic src_a,
    input  logic src_b,
    input  logic use_b,
    input  logic use_reg,
    output logic q_out
);
    typedef struct packed {
        logic ff;
    } path_st_t;

    path_st_t st_d, st_q;
    logic     picked;

    always_comb begin
        picked   = use_b ? src_b : src_a;
        st_d     = st_q;
        st_d.ff  = picked;
        if (quiet) begin
            q_out = 1'b0;
        end else if (use_reg) begin
            q_out = st_q.ff;
        end else begin
            q_out = picked;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.ff == $past(picked))); // R7
endmodule

// File: rtl/clb_cell.sv
module clb_cell
    import clb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_in,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_in,
    output logic             x_out,
    output logic             y_out
);
    logic [CFG_W-1:0] cfg_bits;
    cell_cfg_t        cfg;
    logic             f_res, g_res, h_res;
    logic [N_PATHS-1:0] p_a, p_b, p_use_b, p_reg, p_out;

    clb_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .sin      (cfg_in),
        .bits     (cfg_bits)
    );

    assign cfg = cell_cfg_t'(cfg_bits);

    clb_lut #(.K(LUT_K)) u_lut_f (.tab(cfg.f_tab), .addr(f_in), .dout(f_res));
    clb_lut #(.K(LUT_K)) u_lut_g (.tab(cfg.g_tab), .addr(g_in), .dout(g_res));
    // H address: bit 0 = F result, bit 1 = G result, bit 2 = direct input
    clb_lut #(.K(HK)) u_lut_h (.tab(cfg.h_tab), .addr({h_in, g_res, f_res}), .dout(h_res));

    always_comb begin
        p_a     = {g_res, f_res};
        p_b     = {h_res, h_res};
        p_use_b = {cfg.y_src, cfg.x_src};
        p_reg   = {cfg.y_reg, cfg.x_reg};
    end

    for (genvar gi = 0; gi < N_PATHS; gi++) begin : g_path
        clb_out_path u_path (
            .clk     (clk),
            .rst     (rst),
            .quiet   (cfg_en),
            .src_a   (p_a[gi]),
            .src_b   (p_b[gi]),
            .use_b   (p_use_b[gi]),
            .use_reg (p_reg[gi]),
            .q_out   (p_out[gi])
        );
    end

    assign x_out = p_out[0];
    assign y_out = p_out[1];

    AST_QUIET_WHILE_CFG: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (!x_out && !y_out)); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cfg_bits == '0)); // R1
endmodule

// File: tb/sim_clb_cell.sv
module sim_clb_cell;
    logic       clk = 1'b0;
    logic       rst, cfg_en, cfg_in, h_in;
    logic [3:0] f_in, g_in;
    logic       x_out, y_out;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    clb_cell u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
        .f_in(f_in), .g_in(g_in), .h_in(h_in),
        .x_out(x_out), .y_out(y_out)
    );

    // stimulus vectors {h_in, g_in, f_in}
    localparam logic [8:0] VEC [14] = '{
        9'h000, 9'h1FF, 9'h0A5, 9'h15A, 9'h033, 9'h1C7, 9'h081,
        9'h17E, 9'h0F0, 9'h10F, 9'h06C, 9'h193, 9'h0DB, 9'h124
    };

    localparam logic [43:0] CFG_A = {4'b0000, 8'hB4, 16'h1E69, 16'hA5C3};
    localparam logic [43:0] CFG_B = {4'b0101, 8'hB4, 16'h1E69, 16'hA5C3};
    localparam logic [43:0] CFG_C = {4'b1111, 8'h6D, 16'h3C5A, 16'hF00F};
    localparam logic [43:0] CFG_D = {4'b0000, 8'hFF, 16'hFFFF, 16'hFFFF};
    localparam logic [31:0] T5    = 32'hD3A1_5C6E;
    localparam logic [43:0] CFG_5 = {4'b0001, 8'hCA, T5[31:16], T5[15:0]};
    localparam logic [43:0] CFG_P = {4'b0001, 8'h96, 16'h6996, 16'h6996};

    function automatic logic [1:0] model(input logic [43:0] w, input logic [8:0] v);
        logic f, g, h;
        f = w[v[3:0]];
        g = w[16 + v[7:4]];
        h = w[32 + {v[8], g, f}];
        model = {(w[42] ? h : g), (w[40] ? h : f)};
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [8:0] v);
        f_in = v[3:0];
        g_in = v[7:4];
        h_in = v[8];
    endtask

    task automatic load(input logic [43:0] w);
        @(negedge clk);
        cfg_en = 1'b1;
        for (int i = 43; i >= 0; i--) begin
            cfg_in = w[i];
            @(negedge clk);
            if (i == 21) begin
                #2;
                check(x_out, 1'b0, "R8", "x during config");
                check(y_out, 1'b0, "R8", "y during config");
            end
        end
        cfg_en = 1'b0;
        cfg_in = 1'b0;
    endtask

    task automatic comb_walk(input logic [43:0] w, input string req);
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            apply(VEC[k]);
            #2;
            check(x_out, model(w, VEC[k])[0], req, "x comb");
            check(y_out, model(w, VEC[k])[1], req, "y comb");
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_en = 1'b0; cfg_in = 1'b0;
        apply(9'h1FF);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check(x_out, 1'b0, "R1", "x after reset");
        check(y_out, 1'b0, "R1", "y after reset");

        // R2 R4: plain F and G paths
        load(CFG_A);
        comb_walk(CFG_A, "R4");

        // R5 R6: both paths take H
        load(CFG_B);
        comb_walk(CFG_B, "R5");

        // R7: registered H on both paths
        load(CFG_C);
        begin
            logic [1:0] prev;
            @(negedge clk);
            apply(VEC[0]);
            @(negedge clk);
            prev = model(CFG_C, VEC[0]);
            for (int k = 1; k < 14; k++) begin
                apply(VEC[k]);
                #2;
                check(x_out, prev[0], "R7", "x before edge");
                check(y_out, prev[1], "R7", "y before edge");
                @(negedge clk);
                prev = model(CFG_C, VEC[k]);
                check(x_out, prev[0], "R7", "x after edge");
                check(y_out, prev[1], "R7", "y after edge");
            end
        end

        // R3: cfg_in activity with cfg_en low leaves the configuration alone
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            cfg_in = k[0] ^ k[2];
        end
        cfg_in = 1'b0;
        load(CFG_A);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            cfg_in = ~k[0];
        end
        cfg_in = 1'b0;
        comb_walk(CFG_A, "R3");

        // R1: reset clears a loaded all-ones configuration
        load(CFG_D);
        @(negedge clk);
        apply(9'h0A5);
        #2;
        check(x_out, 1'b1, "R4", "x all-ones table");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(x_out, 1'b0, "R1", "x after second reset");
        check(y_out, 1'b0, "R1", "y after second reset");

        // R9: arbitrary 5-input function
        load(CFG_5);
        for (int v = 0; v < 32; v++) begin
            @(negedge clk);
            f_in = v[3:0];
            g_in = v[3:0];
            h_in = v[4];
            #2;
            check(x_out, T5[v], "R9", "five-input function");
        end

        // R10: nine-input parity
        load(CFG_P);
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            apply(VEC[k]);
            #2;
            check(x_out, ^VEC[k], "R10", "nine-input parity");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule